// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Walk Handshake

This block turns 32-bit virtual addresses into 32-bit physical addresses for 4 KB pages. It keeps a small fully associative set of cached page-table mappings. Each slot holds a virtual page number, a physical page number, a valid flag and a dirty flag. The low 12 address bits are the page offset and pass through unchanged. The upper 20 bits are compared against every slot at once. On a hit, the translated address comes back on the cycle after the lookup is accepted.

When no slot matches, the block raises a walk request toward an external page-table walker and stops accepting lookups until the walker answers. The same happens when a store hits a slot whose dirty flag is clear, so that the walker can mark the page modified. A returned entry with its valid flag set is written into the array and its translation is returned. A returned entry with the valid flag clear produces a page-fault response and is not cached.

Replacement fills empty slots first, lowest index first. Once the array is full, a binary pseudo-LRU tree picks the victim. A flush input empties the whole array in one cycle.

Top module: `tlb_top`

## Requirements
- R1: After reset every slot is empty, `lk_ready` is 1, and `walk_req` and `rsp_valid` are 0. The first lookup of any page therefore starts a walk.
- R2: Hit timing and value.
  - A lookup is accepted on a clock edge where `lk_valid` and `lk_ready` are both 1.
  - An accepted load that matches a valid slot, or an accepted store that matches a valid dirty slot, raises `rsp_valid` for one cycle right after that edge.
  - That response has `rsp_fault` = 0 and `rsp_paddr` = {slot physical page, lookup offset bits [11:0]}.
  - No walk is requested.
- R3: Miss and walk request.
  - An accepted lookup whose page (`lk_vaddr[31:12]`) matches no valid slot raises `walk_req` right after the accepting edge.
  - `walk_vpn` carries that page number.
  - `walk_req` and `walk_vpn` hold steady until an edge where `walk_rsp_valid` is 1.
- R4: When the walker answers with `walk_rsp_ok` = 1:
  - The block raises `rsp_valid` on the next cycle with `rsp_fault` = 0 and `rsp_paddr` = {`walk_rsp_ppn`, lookup offset}.
  - It caches the mapping, so a later lookup of the same page hits without a walk.
  - No page is ever held in two slots.
- R5: When the walker answers with `walk_rsp_ok` = 0, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0. Nothing is cached, so a repeat lookup of that page walks again.
- R6: Store handling.
  - An accepted store (`lk_store` = 1) that matches a slot whose dirty flag is clear is treated as a miss. It raises `walk_req` with `walk_store` = 1.
  - `walk_store` also reflects the store flag on an ordinary miss.
  - Loads hit clean slots normally.
  - The dirty flag of an installed slot is taken from `walk_rsp_dirty`.
- R7: Only one walk can be outstanding.
  - While `walk_req` is 1, `lk_ready` is 0.
  - `lk_valid` is ignored: no extra response and no second walk.
- R8: A cycle with `flush` = 1 empties every slot from the next cycle onward. Every page looked up afterwards walks again.
- R9: Slot choice on install.
  - A walked page that is already present overwrites its own slot.
  - Otherwise the lowest-index empty slot is used.
  - When the array is full, the pseudo-LRU tree picks the victim. Every hit or install points the tree away from the touched slot.
  - Example, with 32 slots filled in index order 0..31 and slot 0 then hit: the next install evicts slot 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty all slots |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup can be accepted (no walk pending) |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| walk_req | output | 1 | Walk request, held until answered |
| walk_vpn | output | 20 | Page number to walk |
| walk_store | output | 1 | Walk was caused by a store |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_ok | input | 1 | Walked entry is valid |
| walk_rsp_dirty | input | 1 | Walked entry dirty flag |
| walk_rsp_ppn | input | 20 | Walked physical page number |

## Verification
The bench fills all 32 slots in index order, hits slot 0, then forces one more install. It checks that slot 16 was evicted and that slots 0 and 17 survived. A design that skipped empty-slot-first selection, or mis-wired the tree, would lose the wrong pages.

It also sends a store to a clean slot, which must walk with the store flag, while loads of the same page hit. A design that compared only page numbers would silently skip the dirty update.

A faulting page is looked up twice. A design that cached invalid entries would return a stale translation on the second try.

Finally, the bench keeps `lk_valid` high on a hitting address throughout a walk. A design that ignored the busy state would produce an unrequested response.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W     = 32;
    localparam int PG_OFF_W = 12;
    localparam int VPN_W    = VA_W - PG_OFF_W;
    localparam int PPN_W    = 20;
    localparam int PA_W     = PPN_W + PG_OFF_W;

    typedef logic [VPN_W-1:0]    vpn_t;
    typedef logic [PPN_W-1:0]    ppn_t;
    typedef logic [PG_OFF_W-1:0] pg_off_t;
    typedef logic [PA_W-1:0]     paddr_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        vpn_t vpn;
        ppn_t ppn;
    } tlb_entry_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_state_e;

    function automatic paddr_t join_pa(ppn_t p, pg_off_t off);
        return {p, off};
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  vpn_t          look_vpn,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  tlb_entry_t    wr_entry,
    output logic [N-1:0]  valid_vec,
    output logic          hit,
    output logic [IW-1:0] hit_idx,
    output ppn_t          hit_ppn,
    output logic          hit_dirty
);

    logic [N-1:0] hit_vec;
    logic [N-1:0] dirty_vec;
    ppn_t         ppn_a [N];

    for (genvar i = 0; i < N; i++) begin : g_slot
        tlb_entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (flush) begin
                ent_q.valid <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(i))) begin
                ent_q <= wr_entry;
            end
        end

        assign valid_vec[i] = ent_q.valid;
        assign dirty_vec[i] = ent_q.dirty;
        assign ppn_a[i]     = ent_q.ppn;
        assign hit_vec[i]   = ent_q.valid && (ent_q.vpn == look_vpn);
    end

    always_comb begin
        hit_idx   = '0;
        hit_ppn   = '0;
        hit_dirty = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                hit_idx   = hit_idx | IW'(i);
                hit_ppn   = hit_ppn | ppn_a[i];
                hit_dirty = hit_dirty | dirty_vec[i];
            end
        end
    end

    assign hit = |hit_vec;

    // R4: a page never sits in two slots
    p_single_match_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R8: flush empties the array on the following cycle
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (valid_vec == '0));

endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] victim
);

    if ((1 << IW) != N) begin : g_bad_size
        $error("tlb_plru: N must be a power of two");
    end

    // node k has children 2k and 2k+1; leaves sit at N..2N-1
    // a node bit of 1 steers the victim search to the right child
    logic [N-1:1] tree_q;
    logic [N-1:1] tree_nxt;

    always_comb begin
        int node;
        tree_nxt = tree_q;
        node     = N + int'(touch_idx);
        for (int l = 0; l < IW; l++) begin
            tree_nxt[node / 2] = ((node % 2) == 0);
            node = node / 2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tree_q <= '0;
        end else if (touch_en) begin
            tree_q <= tree_nxt;
        end
    end

    always_comb begin
        int n;
        n = 1;
        for (int l = 0; l < IW; l++) begin
            n = 2 * n + int'(tree_q[n]);
        end
        victim = IW'(n - N);
    end

    // R9: the slot just touched is never the next victim
    p_touch_moves_victim_r9: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> (victim != $past(touch_idx)));

endmodule

// File: rtl/tlb_walk_ctrl.sv
module tlb_walk_ctrl
    import tlb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lk_valid,
    input  logic       lk_store,
    input  vpn_t       lk_vpn,
    input  pg_off_t    lk_off,
    input  logic       cam_hit,
    input  logic       cam_dirty,
    input  ppn_t       cam_ppn,
    input  logic       wr_rsp_valid,
    input  logic       wr_rsp_ok,
    input  logic       wr_rsp_dirty,
    input  ppn_t       wr_rsp_ppn,
    output logic       lk_ready,
    output logic       rsp_valid,
    output logic       rsp_fault,
    output paddr_t     rsp_paddr,
    output logic       walk_req,
    output vpn_t       walk_vpn,
    output logic       walk_store,
    output logic       install_en,
    output tlb_entry_t install_entry,
    output logic       hit_touch
);

    walk_state_e state_q;
    vpn_t        pend_vpn_q;
    pg_off_t     pend_off_q;
    logic        pend_store_q;

    logic accept;
    logic good_hit;

    assign lk_ready = (state_q == ST_IDLE);
    assign accept   = lk_valid && lk_ready;
    assign good_hit = cam_hit && !(lk_store && !cam_dirty);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            pend_vpn_q   <= '0;
            pend_off_q   <= '0;
            pend_store_q <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_fault    <= 1'b0;
            rsp_paddr    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (good_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_fault <= 1'b0;
                            rsp_paddr <= join_pa(cam_ppn, lk_off);
                        end else begin
                            state_q      <= ST_WALK;
                            pend_vpn_q   <= lk_vpn;
                            pend_off_q   <= lk_off;
                            pend_store_q <= lk_store;
                        end
                    end
                end
                ST_WALK: begin
                    if (wr_rsp_valid) begin
                        state_q   <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_fault <= !wr_rsp_ok;
                        rsp_paddr <= wr_rsp_ok ? join_pa(wr_rsp_ppn, pend_off_q) : '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign walk_req   = (state_q == ST_WALK);
    assign walk_vpn   = pend_vpn_q;
    assign walk_store = pend_store_q;
    assign install_en = walk_req && wr_rsp_valid && wr_rsp_ok;
    assign hit_touch  = accept && cam_hit;

    always_comb begin
        install_entry       = '0;
        install_entry.valid = 1'b1;
        install_entry.dirty = wr_rsp_dirty;
        install_entry.vpn   = pend_vpn_q;
        install_entry.ppn   = wr_rsp_ppn;
    end

    // R7: no lookup is taken while a walk is pending
    p_walk_blocks_lookup_r7: assert property (@(posedge clk) disable iff (rst)
        walk_req |-> !lk_ready);

    // R3: the request and its page stay put until answered
    p_walk_held_r3: assert property (@(posedge clk) disable iff (rst)
        (walk_req && !wr_rsp_valid) |=> (walk_req && $stable(walk_vpn)));

    // R4 / R5: every walker answer yields exactly one response
    p_answer_responds_r4: assert property (@(posedge clk) disable iff (rst)
        (walk_req && wr_rsp_valid) |=> (rsp_valid && (rsp_fault == !$past(wr_rsp_ok))));

endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        lk_valid,
    output logic        lk_ready,
    input  logic [31:0] lk_vaddr,
    input  logic        lk_store,
    output logic        rsp_valid,
    output logic        rsp_fault,
    output logic [31:0] rsp_paddr,
    output logic        walk_req,
    output logic [19:0] walk_vpn,
    output logic        walk_store,
    input  logic        walk_rsp_valid,
    input  logic        walk_rsp_ok,
    input  logic        walk_rsp_dirty,
    input  logic [19:0] walk_rsp_ppn
);

    vpn_t             lk_vpn;
    pg_off_t          lk_off;
    vpn_t             cam_vpn;
    logic [ENTRIES-1:0] valid_vec;
    logic             cam_hit;
    logic [IW-1:0]    cam_idx;
    ppn_t             cam_ppn;
    logic             cam_dirty;
    logic             install_en;
    tlb_entry_t       install_entry;
    logic             hit_touch;
    logic [IW-1:0]    victim;
    logic [IW-1:0]    free_idx;
    logic             free_found;
    logic [IW-1:0]    install_idx;
    logic             touch_en;
    logic [IW-1:0]    touch_idx;

    assign lk_vpn  = lk_vaddr[VA_W-1:PG_OFF_W];
    assign lk_off  = lk_vaddr[PG_OFF_W-1:0];
    // while a walk is pending the array is searched for the walked page
    assign cam_vpn = walk_req ? walk_vpn : lk_vpn;

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx   = IW'(i);
                free_found = 1'b1;
            end
        end
    end

    always_comb begin
        if (cam_hit)         install_idx = cam_idx;
        else if (free_found) install_idx = free_idx;
        else                 install_idx = victim;
    end

    assign touch_en  = hit_touch || install_en;
    assign touch_idx = install_en ? install_idx : cam_idx;

    tlb_cam #(.N(ENTRIES)) u_cam (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .look_vpn  (cam_vpn),
        .wr_en     (install_en),
        .wr_idx    (install_idx),
        .wr_entry  (install_entry),
        .valid_vec (valid_vec),
        .hit       (cam_hit),
        .hit_idx   (cam_idx),
        .hit_ppn   (cam_ppn),
        .hit_dirty (cam_dirty)
    );

    tlb_plru #(.N(ENTRIES)) u_plru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (touch_en),
        .touch_idx (touch_idx),
        .victim    (victim)
    );

    tlb_walk_ctrl u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .lk_valid      (lk_valid),
        .lk_store      (lk_store),
        .lk_vpn        (lk_vpn),
        .lk_off        (lk_off),
        .cam_hit       (cam_hit),
        .cam_dirty     (cam_dirty),
        .cam_ppn       (cam_ppn),
        .wr_rsp_valid  (walk_rsp_valid),
        .wr_rsp_ok     (walk_rsp_ok),
        .wr_rsp_dirty  (walk_rsp_dirty),
        .wr_rsp_ppn    (walk_rsp_ppn),
        .lk_ready      (lk_ready),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_paddr     (rsp_paddr),
        .walk_req      (walk_req),
        .walk_vpn      (walk_vpn),
        .walk_store    (walk_store),
        .install_en    (install_en),
        .install_entry (install_entry),
        .hit_touch     (hit_touch)
    );

    // R2: a usable hit answers on the next cycle with the lookup offset
    p_hit_next_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && cam_hit && !(lk_store && !cam_dirty))
        |=> (rsp_valid && !rsp_fault && !walk_req
             && (rsp_paddr[PG_OFF_W-1:0] == $past(lk_vaddr[PG_OFF_W-1:0]))));

    // R3: a miss starts a walk for the looked-up page
    p_miss_walks_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && !cam_hit)
        |=> (walk_req && (walk_vpn == $past(lk_vaddr[VA_W-1:PG_OFF_W]))));

    // R6: store to a clean slot goes to the walker flagged as a store
    p_clean_store_walks_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_ready && lk_store && cam_hit && !cam_dirty)
        |=> (walk_req && walk_store && !rsp_valid));

    // R5: a faulting answer leaves the array unchanged
    p_fault_not_cached_r5: assert property (@(posedge clk) disable iff (rst)
        (walk_req && walk_rsp_valid && !walk_rsp_ok && !flush)
        |=> (valid_vec == $past(valid_vec)));

    // R9: with room left, a new page fills one more slot instead of evicting
    p_fill_before_evict_r9: assert property (@(posedge clk) disable iff (rst)
        (install_en && !cam_hit && free_found && !flush)
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

endmodule

// File: tb/tb_tlb_top.sv
module tb_tlb_top;

    localparam int CLK_NS   = 10;
    localparam int WATCHDOG = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0;
    logic        lk_ready;
    logic [31:0] lk_vaddr = '0;
    logic        lk_store = 1'b0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_store;
    logic        walk_rsp_valid = 1'b0;
    logic        walk_rsp_ok = 1'b0;
    logic        walk_rsp_dirty = 1'b0;
    logic [19:0] walk_rsp_ppn = '0;

    tlb_top dut (
        .clk            (clk),
        .rst            (rst),
        .flush          (flush),
        .lk_valid       (lk_valid),
        .lk_ready       (lk_ready),
        .lk_vaddr       (lk_vaddr),
        .lk_store       (lk_store),
        .rsp_valid      (rsp_valid),
        .rsp_fault      (rsp_fault),
        .rsp_paddr      (rsp_paddr),
        .walk_req       (walk_req),
        .walk_vpn       (walk_vpn),
        .walk_store     (walk_store),
        .walk_rsp_valid (walk_rsp_valid),
        .walk_rsp_ok    (walk_rsp_ok),
        .walk_rsp_dirty (walk_rsp_dirty),
        .walk_rsp_ppn   (walk_rsp_ppn)
    );

    always #(CLK_NS / 2) clk = ~clk;

    typedef struct {
        logic [31:0] pa;
        logic        flt;
        string       req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    int   rsp_cnt = 0;
    int   walk_cnt = 0;
    logic last_store = 1'b0;
    bit   done = 1'b0;

    function automatic logic [19:0] page_map(logic [19:0] v);
        return v ^ 20'h5A5A5;
    endfunction

    function automatic logic page_bad(logic [19:0] v);
        return v[19:16] == 4'hF;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, expv);
        end
    endtask

    // walker model: answers each request three cycles after it is seen
    initial begin
        forever begin
            @(negedge clk);
            if (walk_req && !rst) begin
                walk_cnt++;
                last_store = walk_store;
                repeat (2) @(negedge clk);
                walk_rsp_valid = 1'b1;
                walk_rsp_ok    = !page_bad(walk_vpn);
                walk_rsp_dirty = walk_store;
                walk_rsp_ppn   = page_map(walk_vpn);
                @(negedge clk);
                walk_rsp_valid = 1'b0;
            end
        end
    end

    // monitor: compares each response against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid && !rst) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R7", "unrequested response", rsp_paddr, 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(rsp_fault == e.flt, e.req, "rsp_fault", 32'(rsp_fault), 32'(e.flt));
                    chk(rsp_paddr == e.pa, e.req, "rsp_paddr", rsp_paddr, e.pa);
                end
                rsp_cnt++;
            end
        end
    end

    task automatic push_exp(input logic [31:0] va, input logic walks, input string req);
        exp_t e;
        e.flt = walks && page_bad(va[31:12]);
        e.pa  = e.flt ? 32'h0 : {page_map(va[31:12]), va[11:0]};
        e.req = req;
        q.push_back(e);
    endtask

    task automatic lookup(input logic [31:0] va, input logic st,
                          input logic exp_walk, input string req);
        int c_walk;
        int c_rsp;
        @(negedge clk);
        while (!lk_ready) @(negedge clk);
        push_exp(va, exp_walk, req);
        c_walk   = walk_cnt;
        c_rsp    = rsp_cnt;
        lk_valid = 1'b1;
        lk_vaddr = va;
        lk_store = st;
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rsp_valid == !exp_walk, req, "response in cycle after accept",
            32'(rsp_valid), 32'(!exp_walk));
        chk(walk_req == exp_walk, req, "walk_req after accept", 32'(walk_req), 32'(exp_walk));
        if (exp_walk) begin
            chk(walk_vpn == va[31:12], req, "walk_vpn", 32'(walk_vpn), 32'(va[31:12]));
            chk(lk_ready == 1'b0, req, "lk_ready low during walk", 32'(lk_ready), 32'h0);
        end
        wait (rsp_cnt == c_rsp + 1);
        chk((walk_cnt - c_walk) == int'(exp_walk), req, "walk count",
            32'(walk_cnt - c_walk), 32'(exp_walk));
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog expired act=%h exp=%h", 32'(rsp_cnt), 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(lk_ready == 1'b1, "R1", "lk_ready after reset", 32'(lk_ready), 32'h1);
        chk(walk_req == 1'b0, "R1", "walk_req after reset", 32'(walk_req), 32'h0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 32'(rsp_valid), 32'h0);

        // R1 / R3 / R4: first lookup walks and installs
        lookup(32'h0001_0123, 1'b0, 1'b1, "R3");
        // R2 / R4: same page now hits with a new offset
        lookup(32'h0001_0FFC, 1'b0, 1'b0, "R2");
        lookup(32'h0001_0000, 1'b0, 1'b0, "R4");
        lookup(32'h0ABC_D456, 1'b0, 1'b1, "R4");
        lookup(32'h0ABC_D001, 1'b0, 1'b0, "R2");

        // R5: faulting page is reported and never cached
        lookup(32'hF000_1234, 1'b0, 1'b1, "R5");
        lookup(32'hF000_1234, 1'b0, 1'b1, "R5");

        // R6: store to clean slot walks with store flag, then hits
        lookup(32'h0001_0040, 1'b1, 1'b1, "R6");
        chk(last_store == 1'b1, "R6", "walk_store on clean store", 32'(last_store), 32'h1);
        lookup(32'h0001_0044, 1'b1, 1'b0, "R6");
        lookup(32'h0001_0048, 1'b0, 1'b0, "R6");
        lookup(32'h0222_2010, 1'b1, 1'b1, "R6");
        chk(last_store == 1'b1, "R6", "walk_store on store miss", 32'(last_store), 32'h1);
        lookup(32'h0222_2014, 1'b1, 1'b0, "R6");
        lookup(32'h0333_3000, 1'b0, 1'b1, "R6");
        chk(last_store == 1'b0, "R6", "walk_store on load miss", 32'(last_store), 32'h0);

        // R7: lookup held high during a walk is ignored
        begin
            int c_rsp;
            int c_walk;
            @(negedge clk);
            while (!lk_ready) @(negedge clk);
            push_exp(32'h0444_4888, 1'b1, "R7");
            c_rsp    = rsp_cnt;
            c_walk   = walk_cnt;
            lk_valid = 1'b1;
            lk_vaddr = 32'h0444_4888;
            lk_store = 1'b0;
            @(negedge clk);
            lk_vaddr = 32'h0001_0100;
            chk(lk_ready == 1'b0, "R7", "lk_ready low while walking", 32'(lk_ready), 32'h0);
            wait (rsp_cnt == c_rsp + 1);
            lk_valid = 1'b0;
            repeat (4) @(negedge clk);
            chk(rsp_cnt == c_rsp + 1, "R7", "response count", 32'(rsp_cnt), 32'(c_rsp + 1));
            chk(walk_cnt == c_walk + 1, "R7", "walk count", 32'(walk_cnt), 32'(c_walk + 1));
        end

        // R8: flush forces a new walk for cached pages
        do_flush();
        lookup(32'h0001_0200, 1'b0, 1'b1, "R8");
        lookup(32'h0ABC_D200, 1'b0, 1'b1, "R8");

        // R9: fill all slots in order, hit slot 0, then evict slot 16
        do_flush();
        for (int i = 0; i < 32; i++) begin
            lookup({20'h00100 + 20'(i), 12'h010}, 1'b0, 1'b1, "R9");
        end
        lookup({20'h00100, 12'h020}, 1'b0, 1'b0, "R9");
        lookup({20'h00200, 12'h030}, 1'b0, 1'b1, "R9");
        lookup({20'h00111, 12'h040}, 1'b0, 1'b0, "R9");
        lookup({20'h00100, 12'h050}, 1'b0, 1'b0, "R9");
        lookup({20'h00200, 12'h060}, 1'b0, 1'b0, "R9");
        lookup({20'h00110, 12'h070}, 1'b0, 1'b1, "R9");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R4", "scoreboard drained", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule